// File: doc/BRIEF.md
# Domain and Page Permission Checker

This block decides what kind of access a memory request may have once a translation descriptor has been found. The request brings a domain number taken from the descriptor, the packed per-domain control word, the two-bit permission code of the page or section, the privilege level of the requester, the two protection bits from the system control word, and whether the request is a write. The block picks out the 2-bit mode of the requested domain, works out an access grade (none, read-only, read/write), and reports whether the request passes, whether it raised a domain fault or a permission fault, and whether the domain mode held the reserved value.

The decision is combinational and is captured in one output register stage. A request is offered with `req_valid`, and the verdict appears on the next clock with `rsp_valid`. Between requests the registered verdict holds its value. Descriptor fetch, address formation and exception entry belong to the surrounding translation logic.

Top module: `acc_perm_check`

## Requirements
- R1: After synchronous reset `rsp_valid`, `rsp_grade`, `rsp_pass`, `rsp_dom_fault`, `rsp_perm_fault` and `rsp_rsv_err` are all 0.
- R2: `rsp_valid` is high in the cycle after a clock edge where `req_valid` was high, and low after an edge where it was low; the verdict belongs to the request of that edge.
- R3: The domain mode used is bits [2*d+1 : 2*d] of `dom_ctrl`, where d is `req_domain`; the other fields of `dom_ctrl` have no effect.
- R4: Domain mode 0 gives grade 0 (none), raises `rsp_dom_fault`, and raises neither `rsp_perm_fault` nor `rsp_rsv_err`, whatever the permission code.
- R5: Domain mode 3 gives grade 2 (read/write) for any permission code, privilege, and protection bits, with no fault.
- R6: Domain mode 2 is reserved: it gives grade 0, raises `rsp_rsv_err`, and raises neither fault flag.
- R7: With domain mode 1 and permission code 0: no protection bit set gives grade 0; only `ctl_sys` set gives grade 1 to a privileged request and 0 to a user request; only `ctl_rom` set gives grade 1 to both; both bits set gives grade 0.
- R8: With domain mode 1: permission code 1 gives grade 2 privileged, 0 user; code 2 gives 2 privileged, 1 user; code 3 gives 2 to both.
- R9: Grade encoding is 0 none, 1 read-only, 2 read/write (3 never appears). `rsp_pass` is 1 exactly when the grade is strictly greater than `req_write` (0 read, 1 write); `rsp_perm_fault` is 1 exactly when domain mode is 1 and the request does not pass.
- R10: In a cycle after an edge with `req_valid` low, the grade and all flags keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_domain | input | 4 | Domain number from the descriptor |
| dom_ctrl | input | 32 | Packed 2-bit mode per domain |
| req_ap | input | 2 | Permission code of the page or section |
| req_user | input | 1 | 1 for an unprivileged requester |
| req_write | input | 1 | 1 for a write, 0 for a read |
| ctl_sys | input | 1 | System protection bit |
| ctl_rom | input | 1 | ROM protection bit |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_grade | output | 2 | 0 none, 1 read-only, 2 read/write |
| rsp_pass | output | 1 | Request allowed |
| rsp_dom_fault | output | 1 | Domain fault |
| rsp_perm_fault | output | 1 | Permission fault |
| rsp_rsv_err | output | 1 | Reserved domain mode seen |

## Verification
The domain decision and the permission decision are both evaluated for every request, so a request can carry a domain mode that faults or is reserved together with a permission code, privilege and write flag that would themselves fail or pass. The bench sweeps every domain mode against every permission code, privilege, protection-bit pair and write flag, placing the mode in a random domain field with random neighbours, and judges that the domain outcome wins: a domain fault or reserved mode never comes with a permission fault, and a permission fault only ever comes from mode 1 with a grade not above the write flag.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int MODE_W  = 2;
    localparam int GRADE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        DM_DENY  = 2'd0,
        DM_CHECK = 2'd1,
        DM_RSV   = 2'd2,
        DM_FULL  = 2'd3
    } dmode_t;

    typedef enum logic [GRADE_W-1:0] {
        GR_NONE = 2'd0,
        GR_RO   = 2'd1,
        GR_RW   = 2'd2
    } grade_t;

    typedef struct packed {
        grade_t grade;
        logic   pass;
        logic   dom_fault;
        logic   perm_fault;
        logic   rsv_err;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{grade: GR_NONE, pass: 1'b0,
                                          dom_fault: 1'b0, perm_fault: 1'b0,
                                          rsv_err: 1'b0};

    // Grade given by a permission code when the domain asks for checking.
    function automatic grade_t code_grade(input logic [1:0] ap,
                                          input logic user,
                                          input logic sys_bit,
                                          input logic rom_bit);
        grade_t g;
        case (ap)
            2'd0: begin
                case ({sys_bit, rom_bit})
                    2'b10:   g = user ? GR_NONE : GR_RO;
                    2'b01:   g = GR_RO;
                    default: g = GR_NONE;
                endcase
            end
            2'd1:    g = user ? GR_NONE : GR_RW;
            2'd2:    g = user ? GR_RO : GR_RW;
            default: g = GR_RW;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/dom_mode_pick.sv
module dom_mode_pick
    import perm_pkg::*;
#(
    parameter int NUM_DOMAINS = 16,
    localparam int DOM_W  = $clog2(NUM_DOMAINS),
    localparam int CTRL_W = MODE_W * NUM_DOMAINS
) (
    input  logic [DOM_W-1:0]  domain,
    input  logic [CTRL_W-1:0] ctrl,
    output dmode_t            mode
);

    logic [MODE_W-1:0] fields [NUM_DOMAINS];

    for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_field
        assign fields[g] = ctrl[MODE_W*g +: MODE_W];
    end

    assign mode = dmode_t'(fields[domain]);

endmodule

// File: rtl/ap_grader.sv
module ap_grader
    import perm_pkg::*;
(
    input  logic [1:0] ap,
    input  logic       user,
    input  logic       sys_bit,
    input  logic       rom_bit,
    output grade_t     grade
);

    always_comb begin
        grade = code_grade(ap, user, sys_bit, rom_bit);
    end

endmodule

// File: rtl/verdict_merge.sv
module verdict_merge
    import perm_pkg::*;
(
    input  dmode_t   mode,
    input  grade_t   code_gr,
    input  logic     write,
    output verdict_t verdict
);

    grade_t final_gr;

    always_comb begin
        case (mode)
            DM_CHECK: final_gr = code_gr;
            DM_FULL:  final_gr = GR_RW;
            default:  final_gr = GR_NONE;
        endcase

        verdict            = VERDICT_IDLE;
        verdict.grade      = final_gr;
        verdict.pass       = (final_gr > {1'b0, write});
        verdict.dom_fault  = (mode == DM_DENY);
        verdict.rsv_err    = (mode == DM_RSV);
        verdict.perm_fault = (mode == DM_CHECK) && !(final_gr > {1'b0, write});
    end

endmodule

// File: rtl/acc_perm_check.sv
module acc_perm_check
    import perm_pkg::*;
#(
    parameter int NUM_DOMAINS = 16,
    localparam int DOM_W  = $clog2(NUM_DOMAINS),
    localparam int CTRL_W = MODE_W * NUM_DOMAINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DOM_W-1:0]  req_domain,
    input  logic [CTRL_W-1:0] dom_ctrl,
    input  logic [1:0]        req_ap,
    input  logic              req_user,
    input  logic              req_write,
    input  logic              ctl_sys,
    input  logic              ctl_rom,
    output logic              rsp_valid,
    output logic [1:0]        rsp_grade,
    output logic              rsp_pass,
    output logic              rsp_dom_fault,
    output logic              rsp_perm_fault,
    output logic              rsp_rsv_err
);

    dmode_t   cur_mode;
    grade_t   cur_code_gr;
    verdict_t cur_verdict;
    verdict_t held;

    dom_mode_pick #(.NUM_DOMAINS(NUM_DOMAINS)) u_pick (
        .domain (req_domain),
        .ctrl   (dom_ctrl),
        .mode   (cur_mode)
    );

    ap_grader u_grade (
        .ap      (req_ap),
        .user    (req_user),
        .sys_bit (ctl_sys),
        .rom_bit (ctl_rom),
        .grade   (cur_code_gr)
    );

    verdict_merge u_merge (
        .mode    (cur_mode),
        .code_gr (cur_code_gr),
        .write   (req_write),
        .verdict (cur_verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            held      <= VERDICT_IDLE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                held <= cur_verdict;
            end
        end
    end

    assign rsp_grade      = held.grade;
    assign rsp_pass       = held.pass;
    assign rsp_dom_fault  = held.dom_fault;
    assign rsp_perm_fault = held.perm_fault;
    assign rsp_rsv_err    = held.rsv_err;

endmodule

// File: rtl/acc_perm_check_sva.sv
module acc_perm_check_sva #(
    parameter int NUM_DOMAINS = 16,
    localparam int DOM_W  = $clog2(NUM_DOMAINS),
    localparam int CTRL_W = 2 * NUM_DOMAINS
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [DOM_W-1:0]  req_domain,
    input logic [CTRL_W-1:0] dom_ctrl,
    input logic              rsp_valid,
    input logic [1:0]        rsp_grade,
    input logic              rsp_pass,
    input logic              rsp_dom_fault,
    input logic              rsp_perm_fault,
    input logic              rsp_rsv_err
);

    logic [1:0] in_mode;
    assign in_mode = dom_ctrl[{req_domain, 1'b0} +: 2];

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R4
    dom_fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_dom_fault |-> (rsp_grade == 2'd0) && !rsp_perm_fault && !rsp_rsv_err);

    // R5
    full_mode_rw_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_mode == 2'd3) |=> (rsp_grade == 2'd2) && rsp_pass);

    // R6
    rsv_clean_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_rsv_err |-> (rsp_grade == 2'd0) && !rsp_dom_fault && !rsp_perm_fault);

    // R9
    grade_code_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_grade != 2'd3);

    // R9
    pass_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_pass |-> !rsp_dom_fault && !rsp_perm_fault && !rsp_rsv_err);

    // R10
    hold_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_grade) && $stable(rsp_pass) && $stable(rsp_dom_fault)
                       && $stable(rsp_perm_fault) && $stable(rsp_rsv_err));

endmodule

bind acc_perm_check acc_perm_check_sva #(.NUM_DOMAINS(NUM_DOMAINS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_domain     (req_domain),
    .dom_ctrl       (dom_ctrl),
    .rsp_valid      (rsp_valid),
    .rsp_grade      (rsp_grade),
    .rsp_pass       (rsp_pass),
    .rsp_dom_fault  (rsp_dom_fault),
    .rsp_perm_fault (rsp_perm_fault),
    .rsp_rsv_err    (rsp_rsv_err)
);

// File: tb/sim_acc_perm_check.sv
module sim_acc_perm_check;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [3:0]  req_domain;
    logic [31:0] dom_ctrl;
    logic [1:0]  req_ap;
    logic        req_user;
    logic        req_write;
    logic        ctl_sys;
    logic        ctl_rom;
    logic        rsp_valid;
    logic [1:0]  rsp_grade;
    logic        rsp_pass;
    logic        rsp_dom_fault;
    logic        rsp_perm_fault;
    logic        rsp_rsv_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_perm_check u0 (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_domain     (req_domain),
        .dom_ctrl       (dom_ctrl),
        .req_ap         (req_ap),
        .req_user       (req_user),
        .req_write      (req_write),
        .ctl_sys        (ctl_sys),
        .ctl_rom        (ctl_rom),
        .rsp_valid      (rsp_valid),
        .rsp_grade      (rsp_grade),
        .rsp_pass       (rsp_pass),
        .rsp_dom_fault  (rsp_dom_fault),
        .rsp_perm_fault (rsp_perm_fault),
        .rsp_rsv_err    (rsp_rsv_err)
    );

    // Expected grade from the requirement tables (R4..R8).
    function automatic logic [1:0] exp_grade(input logic [1:0] mode, input logic [1:0] ap,
                                             input logic user, input logic sys_b,
                                             input logic rom_b);
        if (mode == 2'd3) return 2'd2;
        if (mode != 2'd1) return 2'd0;
        case (ap)
            2'd0: begin
                if (sys_b && !rom_b) return user ? 2'd0 : 2'd1;
                if (!sys_b && rom_b) return 2'd1;
                return 2'd0;
            end
            2'd1: return user ? 2'd0 : 2'd2;
            2'd2: return user ? 2'd1 : 2'd2;
            default: return 2'd2;
        endcase
    endfunction

    // Packed expected verdict: {grade, pass, dom_fault, perm_fault, rsv_err}
    function automatic logic [5:0] exp_verdict(input logic [1:0] mode, input logic [1:0] ap,
                                               input logic user, input logic sys_b,
                                               input logic rom_b, input logic wr);
        logic [1:0] g;
        logic       p;
        g = exp_grade(mode, ap, user, sys_b, rom_b);
        p = (g > {1'b0, wr});
        return {g, p, mode == 2'd0, (mode == 2'd1) && !p, mode == 2'd2};
    endfunction

    function automatic logic [5:0] got_verdict();
        return {rsp_grade, rsp_pass, rsp_dom_fault, rsp_perm_fault, rsp_rsv_err};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Drive one request at a negedge; next negedge the verdict is registered.
    task automatic issue(input logic [3:0] dom, input logic [31:0] ctrl, input logic [1:0] ap,
                         input logic user, input logic sys_b, input logic rom_b,
                         input logic wr);
        req_valid  = 1'b1;
        req_domain = dom;
        dom_ctrl   = ctrl;
        req_ap     = ap;
        req_user   = user;
        ctl_sys    = sys_b;
        ctl_rom    = rom_b;
        req_write  = wr;
        @(negedge clk);
    endtask

    function automatic logic [31:0] place_mode(input logic [31:0] base, input logic [3:0] dom,
                                                input logic [1:0] mode);
        logic [31:0] r;
        r = base;
        r[{dom, 1'b0} +: 2] = mode;
        return r;
    endfunction

    initial begin
        logic [5:0] snap;
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid = 1'b0; req_domain = '0; dom_ctrl = '0;
        req_ap = '0; req_user = 1'b0; req_write = 1'b0; ctl_sys = 1'b0; ctl_rom = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 verdict", {26'd0, got_verdict()}, 32'd0);

        // Full sweep of mode x ap x user x sys x rom x write, random domain and neighbours.
        for (int mode = 0; mode < 4; mode++) begin
            for (int ap = 0; ap < 4; ap++) begin
                for (int k = 0; k < 16; k++) begin
                    logic [3:0]  dom;
                    logic [31:0] ctrl;
                    dom  = 4'($urandom_range(0, 15));
                    ctrl = place_mode($urandom(), dom, 2'(mode));
                    issue(dom, ctrl, 2'(ap), k[0], k[1], k[2], k[3]);
                    // R2: verdict one cycle later with valid
                    check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
                    // R4 R5 R6 R7 R8 R9: verdict against reference tables
                    check(mode == 0 ? "R4 deny mode" : mode == 2 ? "R6 reserved mode" :
                          mode == 3 ? "R5 full mode" : (ap == 0 ? "R7 code0" : "R8 code123"),
                          {26'd0, got_verdict()},
                          {26'd0, exp_verdict(2'(mode), 2'(ap), k[0], k[1], k[2], k[3])});
                end
            end
        end

        // R3: each domain selects its own field; neighbours carry the opposite extreme.
        for (int d = 0; d < 16; d++) begin
            issue(4'(d), place_mode(32'h0000_0000, 4'(d), 2'd3), 2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
            check("R3 own field full", {30'd0, rsp_grade}, 32'd2);
            issue(4'(d), place_mode(32'hFFFF_FFFF, 4'(d), 2'd0), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
            check("R3 own field deny", {31'd0, rsp_dom_fault}, 32'd1);
        end

        // R9: read passes and write fails on a read-only grade.
        issue(4'd5, place_mode('0, 4'd5, 2'd1), 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 ro read pass", {31'd0, rsp_pass}, 32'd1);
        issue(4'd5, place_mode('0, 4'd5, 2'd1), 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R9 ro write perm fault", {30'd0, rsp_pass, rsp_perm_fault}, 32'd1);

        // R10: idle cycles with changing inputs leave the verdict unchanged.
        snap = got_verdict();
        req_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            dom_ctrl   = $urandom();
            req_domain = 4'($urandom_range(0, 15));
            req_ap     = 2'($urandom_range(0, 3));
            req_user   = 1'($urandom_range(0, 1));
            req_write  = 1'($urandom_range(0, 1));
            @(negedge clk);
            check("R10 idle valid low", {31'd0, rsp_valid}, 32'd0);
            check("R10 idle hold", {26'd0, got_verdict()}, {26'd0, snap});
        end

        // Random back-to-back requests.
        for (int i = 0; i < 300; i++) begin
            logic [3:0]  dom;
            logic [31:0] ctrl;
            logic [1:0]  ap;
            logic [4:0]  bits;
            dom  = 4'($urandom_range(0, 15));
            ctrl = $urandom();
            ap   = 2'($urandom_range(0, 3));
            bits = 5'($urandom_range(0, 31));
            issue(dom, ctrl, ap, bits[0], bits[1], bits[2], bits[3]);
            check("R9 random verdict", {26'd0, got_verdict()},
                  {26'd0, exp_verdict(ctrl[{dom, 1'b0} +: 2], ap, bits[0], bits[1], bits[2], bits[3])});
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule